// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block is a small, register-mapped performance monitor for a processor subsystem. It holds one free-running cycle counter and three event counters. Each event counter is programmed with a 7-bit event code and counts the cycles in which the matching line of a 128-bit event pulse vector is high. Software reaches it over a plain synchronous register bus: word address, write enable, write data, and read data that follows the address combinationally.

A global run bit in the control word gates all counting. Separate set and clear words turn individual counters on and off without a read-modify-write. The three event counters sit behind a selector word, so one type word and one count word serve all of them. The cycle counter can be slowed to one step per 64 enabled clocks. A software-increment word lets firmware bump counters that are programmed with event code 0x00.

Top module: `perf_monitor`

## Requirements
- R1: After reset every readable word returns 0: control, enable mask, selector, all event types, all event counts and the cycle count.
- R2: No counter changes unless control bit 0 (run) is 1 and the counter's own enable bit is set. Direct writes and reset strobes are the only exceptions.
- R3: Control word (address 0): a write with bit 1 set clears all event counts, and a write with bit 2 set clears the cycle count. Both bits read back as 0, while bits 0 and 3 read back as written.
- R4: With control bit 3 set, the cycle count (address 7) steps once per 64 enabled clocks. The 6-bit prescaler restarts from zero when bit 3 changes value, when the cycle count is cleared by strobe, or when the cycle count is written.
- R5: A write to the enable-set word (address 1) sets each enable whose data bit is 1, and a write to the enable-clear word (address 2) clears each such enable. Data bit 31 is the cycle counter and bits 0..2 are event counters 0..2. Zero bits change nothing, and both words read back the current mask.
- R6: The selector word (address 4, 5 bits) picks event counter 0..2. The type word (address 5, 7 bits) and the count word (address 6) then read and write that counter.
- R7: While the selector holds a value above 2, the type word and the count word read 0, and writes to them change no counter.
- R8: An event counter with code c, where c is neither 0x00 nor 0x11, adds 1 at each clock edge where event input c is high. Code 0x11 adds 1 on every enabled clock. Code 0x00 ignores the event inputs.
- R9: A write to the software-increment word (address 3) with bit n set adds 1 to event counter n only if run is on, counter n is enabled, and its code is 0x00. This word reads 0.
- R10: A written count value takes effect at the next edge and takes the place of any increment due in that cycle.
- R11: Every counter is 32 bits wide, wraps from 0xFFFFFFFF to 0, and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Word address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 128 | One-cycle event pulses indexed by event code |

## Verification
The hardest case to reach is the prescaler restart. A control write that flips the divide bit, or a direct write to the cycle count, has to land in the middle of a 64-clock prescale window. Only then does a missing restart show up as a step one window early or late. The stimulus runs long divided stretches and breaks them with cycle-count writes and divide toggles at uneven offsets. A behavioural model keeps its own prescale count, and the cycle count is compared against that model on every clock. The write-wins-over-increment case is driven by holding every event input high while a count is written.

// File: rtl/perf_monitor_pkg.sv
package perf_monitor_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_ENSET  = 3'd1,
        REG_ENCLR  = 3'd2,
        REG_SWINC  = 3'd3,
        REG_SELECT = 3'd4,
        REG_TYPE   = 3'd5,
        REG_EVCNT  = 3'd6,
        REG_CYCCNT = 3'd7
    } reg_addr_e;

    localparam int CTRL_RUN_BIT   = 0;
    localparam int CTRL_EVCLR_BIT = 1;
    localparam int CTRL_CYCLR_BIT = 2;
    localparam int CTRL_DIV_BIT   = 3;
    localparam int CYC_EN_BIT     = 31;

    localparam int CODE_SWINC = 0;
    localparam int CODE_CLOCK = 'h11;

endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
    parameter int PRE_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic active_i,
    output logic tick_o
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (active_i) begin
            cnt_d = cnt_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = active_i && !restart_i && (cnt_q == {PRE_W{1'b1}});

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0)); // R4
    AST_PRE_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R4

endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
    parameter int CNT_W   = 32,
    parameter int CODE_W  = 7,
    parameter int NUM_EVT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic              swinc_i,
    input  logic              clr_i,
    input  logic              type_we_i,
    input  logic [CODE_W-1:0] type_i,
    input  logic              cnt_we_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CODE_W-1:0] type_o,
    output logic [CNT_W-1:0]  count_o
);
    import perf_monitor_pkg::*;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
    } evc_state_t;

    evc_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        if (st_q.code == CODE_W'(CODE_SWINC)) begin
            hit = swinc_i;
        end else if (st_q.code == CODE_W'(CODE_CLOCK)) begin
            hit = 1'b1;
        end else begin
            hit = evt_i[st_q.code];
        end

        if (type_we_i) begin
            st_d.code = type_i;
        end

        if (cnt_we_i) begin
            st_d.count = cnt_i;
        end else if (clr_i) begin
            st_d.count = '0;
        end else if (run_i && hit) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign type_o  = st_q.code;
    assign count_o = st_q.count;

    AST_EVC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_we_i && !clr_i) |=> $stable(count_o)); // R2
    AST_EVC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we_i |=> (count_o == $past(cnt_i))); // R10
    AST_EVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cnt_we_i) |=> (count_o == '0)); // R3
    AST_EVC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !cnt_we_i) |=> ((count_o == $past(count_o)) ||
                                    (count_o == $past(count_o) + CNT_W'(1)))); // R11

endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             div_i,
    input  logic             div_chg_i,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             restart;
    logic             tick;
    logic             step;

    assign restart = clr_i || we_i || div_chg_i;

    pmu_prescaler #(
        .PRE_W (PRE_W)
    ) i_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .active_i  (run_i && div_i),
        .tick_o    (tick)
    );

    always_comb begin
        step  = div_i ? tick : run_i;
        cnt_d = cnt_q;
        if (we_i) begin
            cnt_d = wdata_i;
        end else if (clr_i) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    AST_CYC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !we_i && !clr_i) |=> $stable(count_o)); // R2
    AST_CYC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (count_o == $past(wdata_i))); // R10
    AST_CYC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !we_i) |=> (count_o == '0)); // R3

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor #(
    parameter int CNT_W   = 32,
    parameter int CODE_W  = 7,
    parameter int NUM_CNT = 3,
    parameter int SEL_W   = 5,
    parameter int PRE_W   = 6,
    parameter int ADDR_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic [(1<<CODE_W)-1:0] evt_in
);
    import perf_monitor_pkg::*;

    localparam int NUM_EVT = 1 << CODE_W;

    typedef struct packed {
        logic               run;
        logic               div;
        logic               cyc_en;
        logic [NUM_CNT-1:0] mask;
        logic [SEL_W-1:0]   sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic wr_ctrl, wr_set, wr_clr, wr_swinc, wr_sel, wr_type, wr_cnt, wr_cyc;
    logic sel_ok;
    logic div_chg;
    logic [CODE_W-1:0] type_w [NUM_CNT];
    logic [CNT_W-1:0]  cnt_w  [NUM_CNT];
    logic [CNT_W-1:0]  cyc_w;
    logic [CODE_W-1:0] sel_type;
    logic [CNT_W-1:0]  sel_cnt;
    logic [CNT_W-1:0]  mask_word;

    // write decode
    always_comb begin
        wr_ctrl  = bus_we && (bus_addr == REG_CTRL);
        wr_set   = bus_we && (bus_addr == REG_ENSET);
        wr_clr   = bus_we && (bus_addr == REG_ENCLR);
        wr_swinc = bus_we && (bus_addr == REG_SWINC);
        wr_sel   = bus_we && (bus_addr == REG_SELECT);
        wr_type  = bus_we && (bus_addr == REG_TYPE);
        wr_cnt   = bus_we && (bus_addr == REG_EVCNT);
        wr_cyc   = bus_we && (bus_addr == REG_CYCCNT);
        sel_ok   = (ctl_q.sel < SEL_W'(NUM_CNT));
        div_chg  = wr_ctrl && (bus_wdata[CTRL_DIV_BIT] != ctl_q.div);
    end

    // control state next value
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.run = bus_wdata[CTRL_RUN_BIT];
            ctl_d.div = bus_wdata[CTRL_DIV_BIT];
        end
        if (wr_set) begin
            ctl_d.mask   = ctl_q.mask | bus_wdata[NUM_CNT-1:0];
            ctl_d.cyc_en = ctl_q.cyc_en | bus_wdata[CYC_EN_BIT];
        end
        if (wr_clr) begin
            ctl_d.mask   = ctl_q.mask & ~bus_wdata[NUM_CNT-1:0];
            ctl_d.cyc_en = ctl_q.cyc_en & ~bus_wdata[CYC_EN_BIT];
        end
        if (wr_sel) begin
            ctl_d.sel = bus_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // event counters
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_evc
        logic hit_sel;
        assign hit_sel = sel_ok && (ctl_q.sel == SEL_W'(g));

        pmu_event_counter #(
            .CNT_W   (CNT_W),
            .CODE_W  (CODE_W),
            .NUM_EVT (NUM_EVT)
        ) i_evc (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (ctl_q.run && ctl_q.mask[g]),
            .evt_i     (evt_in),
            .swinc_i   (wr_swinc && bus_wdata[g]),
            .clr_i     (wr_ctrl && bus_wdata[CTRL_EVCLR_BIT]),
            .type_we_i (wr_type && hit_sel),
            .type_i    (bus_wdata[CODE_W-1:0]),
            .cnt_we_i  (wr_cnt && hit_sel),
            .cnt_i     (bus_wdata),
            .type_o    (type_w[g]),
            .count_o   (cnt_w[g])
        );

        AST_SEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_type || wr_cnt) && !sel_ok) |=> ($stable(type_w[g]) &&
                                                 ($stable(cnt_w[g]) || ctl_q.run))); // R7
    end

    // cycle counter
    pmu_cycle_counter #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) i_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q.run && ctl_q.cyc_en),
        .div_i     (ctl_q.div),
        .div_chg_i (div_chg),
        .clr_i     (wr_ctrl && bus_wdata[CTRL_CYCLR_BIT]),
        .we_i      (wr_cyc),
        .wdata_i   (bus_wdata),
        .count_o   (cyc_w)
    );

    // read mux
    always_comb begin
        sel_type = '0;
        sel_cnt  = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel_ok && (ctl_q.sel == SEL_W'(i))) begin
                sel_type = type_w[i];
                sel_cnt  = cnt_w[i];
            end
        end
        mask_word                      = '0;
        mask_word[NUM_CNT-1:0]         = ctl_q.mask;
        mask_word[CYC_EN_BIT]          = ctl_q.cyc_en;

        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_RUN_BIT] = ctl_q.run;
                bus_rdata[CTRL_DIV_BIT] = ctl_q.div;
            end
            REG_ENSET, REG_ENCLR: bus_rdata = mask_word;
            REG_SELECT: bus_rdata[SEL_W-1:0] = ctl_q.sel;
            REG_TYPE:   bus_rdata[CODE_W-1:0] = sel_type;
            REG_EVCNT:  bus_rdata = sel_cnt;
            REG_CYCCNT: bus_rdata = cyc_w;
            default:    bus_rdata = '0;
        endcase
    end

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_clr) |=> ((ctl_q.mask & $past(bus_wdata[NUM_CNT-1:0])) ==
                                 $past(bus_wdata[NUM_CNT-1:0]))); // R5
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((ctl_q.mask & $past(bus_wdata[NUM_CNT-1:0])) == '0)); // R5
    AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> ($stable(ctl_q.mask) && $stable(ctl_q.cyc_en))); // R5

endmodule

// File: tb/test_perf_monitor.sv
module test_perf_monitor;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] evt_in = '0;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit evt_all = 1'b0;
    bit evt_quiet = 1'b0;

    // reference model state
    bit          m_run, m_div, m_cyc_en;
    bit [2:0]    m_mask;
    int          m_sel;
    int          m_type [3];
    logic [31:0] m_cnt [3];
    logic [31:0] m_cyc;
    int          m_pre;

    perf_monitor i_perf_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] v;
        v = '0;
        case (a)
            0: begin v[0] = m_run; v[3] = m_div; end
            1, 2: begin v[2:0] = m_mask; v[31] = m_cyc_en; end
            4: v = 32'(m_sel);
            5: v = (m_sel < 3) ? 32'(m_type[m_sel]) : 32'd0;
            6: v = (m_sel < 3) ? m_cnt[m_sel] : 32'd0;
            7: v = m_cyc;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string addr_tag(input int a);
        case (a)
            0: return "R3";
            1, 2: return "R5";
            3: return "R9";
            4, 5: return "R6";
            6: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h t=%0t", tag, bus_addr, act, exp, $time);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_div = 0; m_cyc_en = 0; m_mask = '0; m_sel = 0; m_pre = 0;
            m_cyc = '0;
            for (int i = 0; i < 3; i++) begin m_type[i] = 0; m_cnt[i] = '0; end
        end else begin
            bit o_run, o_div, o_cyc_en, restart, crun, step, hit;
            bit [2:0] o_mask;
            int o_sel, a;
            int o_type [3];
            a = int'(bus_addr);
            o_run = m_run; o_div = m_div; o_cyc_en = m_cyc_en; o_mask = m_mask; o_sel = m_sel;
            for (int i = 0; i < 3; i++) o_type[i] = m_type[i];
            // event counters
            for (int i = 0; i < 3; i++) begin
                if (o_type[i] == 0) hit = bus_we && a == 3 && bus_wdata[i];
                else if (o_type[i] == 'h11) hit = 1;
                else hit = evt_in[o_type[i]];
                if (bus_we && a == 6 && o_sel == i) m_cnt[i] = bus_wdata;
                else if (bus_we && a == 0 && bus_wdata[1]) m_cnt[i] = '0;
                else if (o_run && o_mask[i] && hit) m_cnt[i] = m_cnt[i] + 32'd1;
                if (bus_we && a == 5 && o_sel == i) m_type[i] = int'(bus_wdata[6:0]);
            end
            // cycle counter with prescale
            restart = (bus_we && a == 7) ||
                      (bus_we && a == 0 && (bus_wdata[2] || (bus_wdata[3] != o_div)));
            crun = o_run && o_cyc_en;
            step = o_div ? (crun && m_pre == 63 && !restart) : crun;
            if (restart) m_pre = 0;
            else if (crun && o_div) m_pre = (m_pre + 1) % 64;
            if (bus_we && a == 7) m_cyc = bus_wdata;
            else if (bus_we && a == 0 && bus_wdata[2]) m_cyc = '0;
            else if (step) m_cyc = m_cyc + 32'd1;
            // control words
            if (bus_we && a == 0) begin m_run = bus_wdata[0]; m_div = bus_wdata[3]; end
            if (bus_we && a == 1) begin m_mask = o_mask | bus_wdata[2:0]; m_cyc_en = o_cyc_en | bus_wdata[31]; end
            if (bus_we && a == 2) begin m_mask = o_mask & ~bus_wdata[2:0]; m_cyc_en = o_cyc_en & ~bus_wdata[31]; end
            if (bus_we && a == 4) m_sel = int'(bus_wdata[4:0]);
        end
    end

    // event stimulus, changed away from the edge
    always @(posedge clk) begin
        #2;
        if (evt_all) evt_in = '1;
        else if (evt_quiet) evt_in = '0;
        else evt_in = {$urandom, $urandom, $urandom, $urandom};
    end

    // compare the addressed word with the model on every clock
    always @(negedge clk) begin
        if (rst_n) check(addr_tag(int'(bus_addr)), bus_rdata, model_read(int'(bus_addr)));
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = 3'(a); bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic look(input int a, input string tag);
        @(posedge clk); #2;
        bus_addr = 3'(a); bus_we = 1'b0;
        @(negedge clk);
        check(tag, bus_rdata, model_read(a));
    endtask

    task automatic idle(input int n, input int a);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            bus_addr = 3'(a); bus_we = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state of every word
        for (int a = 0; a < 8; a++) look(a, "R1");
        @(negedge clk); check("R1", bus_rdata, 32'd0);

        // program types: counter0 clock, counter1 code 5, counter2 software
        wr(4, 0); wr(5, 'h11);
        wr(4, 1); wr(5, 5);
        wr(4, 2); wr(5, 0);
        look(5, "R6");
        wr(1, 32'h8000_0007);
        look(1, "R5"); look(2, "R5");

        // R2: run off, nothing moves
        idle(10, 6); look(6, "R2"); look(7, "R2");

        // R8: running with random events
        wr(0, 32'h1);
        idle(30, 7);
        for (int s = 0; s < 3; s++) begin wr(4, s); look(6, "R8"); look(5, "R6"); end

        // R9: software increment only reaches code-0 counter
        wr(3, 32'h7); wr(3, 32'h7);
        look(6, "R9");
        wr(2, 32'h4);
        wr(3, 32'h4); look(6, "R9");
        wr(2, 32'h0); look(2, "R5");
        wr(1, 32'h4);

        // R7: selector out of range
        wr(4, 6); look(5, "R7"); look(6, "R7");
        wr(5, 'h22); wr(6, 32'h1234_5678);
        look(5, "R7"); look(6, "R7");
        wr(4, 31); look(6, "R7");
        for (int s = 0; s < 3; s++) begin wr(4, s); look(5, "R7"); end

        // R10: write beats an increment in the same cycle
        evt_all = 1'b1;
        wr(4, 1); wr(6, 32'h0000_0100); look(6, "R10");
        idle(4, 6); look(6, "R10");
        evt_all = 1'b0;

        // R11: wrap of event and cycle counters
        wr(4, 0); wr(6, 32'hFFFF_FFFE);
        idle(3, 6); look(6, "R11");
        wr(7, 32'hFFFF_FFFF); look(7, "R11"); idle(2, 7); look(7, "R11");

        // R4: divided cycle counting with restarts mid-window
        evt_quiet = 1'b1;
        wr(0, 32'hD);
        idle(150, 7); look(7, "R4");
        idle(37, 7); wr(7, 32'h10); idle(70, 7); look(7, "R4");
        idle(21, 7); wr(0, 32'h1); idle(5, 7); look(7, "R4");
        wr(0, 32'h9); idle(100, 7); look(7, "R4");
        wr(2, 32'h8000_0000); idle(80, 7); look(7, "R2");
        wr(1, 32'h8000_0000); idle(64, 7); look(7, "R4");
        evt_quiet = 1'b0;

        // R3: reset strobes and readback of control
        wr(0, 32'h3); look(0, "R3"); look(7, "R3");
        for (int s = 0; s < 3; s++) begin wr(4, s); look(6, "R3"); end
        wr(0, 32'h5); look(7, "R3"); look(0, "R3");
        wr(0, 32'h0); idle(10, 7); look(7, "R2");

        idle(5, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule